// File: doc/BRIEF.md
# Temperature Sensor Measurement Sequencer

This block decides when an on-chip temperature sensor converts, collects the signed result and presents it to a processor through a small byte-wide register port. The sensor front end is reached through a request/done handshake. The block raises a request and holds it. The front end answers with a one-cycle done strobe and an 11-bit two's-complement code, which covers -1024 to +1023.

The power-mode input chooses what starts a measurement. In the two active modes (0 and 1), software launches a single conversion by writing a start bit. In the two low-power modes (2 and 3), the processor may be halted. An internal counter of slow timebase ticks then launches conversions at a programmable interval, with no help from software. Each completed conversion updates both result bytes on the same edge and pulses a done interrupt for one cycle. The block also drives the sensor supply select and the battery-measure select. In battery-backed mode (mode 1) it forces them to agree.

Register map, selected by `addr` (reads are combinational):
- 0, control: bit 6 = start (write 1 to launch; reads 1 until the conversion ends), bit 5 = busy (read only), bit 0 = sensor supply select.
- 1, configuration: bits [2:0] = period field p, bit 4 = battery-measure select.
- 2, result high: code bits [10:3].
- 3, result low: bits [7:5] = code bits [2:0], bits [4:0] read 0.

Top module: `tsens_seq`

## Requirements
- R1: After reset, `sns_req` and `done_irq` are 0, all four registers read 0x00, and both select outputs are 0.
- R2: In mode 0 or 1 with no conversion running, a write to address 0 with bit 6 set raises `sns_req` and control bit 5 (busy) from the next cycle. Control bit 6 also reads 1 from that cycle.
- R3: `sns_req` stays high until `sns_done` is seen. On the edge that samples `sns_done`, busy, start and `sns_req` all return to 0.
- R4: A start write is ignored in modes 2 and 3, and it is also ignored while a conversion is running. An ignored start raises no request, leaves bit 6 at 0 in the low-power modes, and queues nothing.
- R5: In modes 2 and 3, the block launches a conversion on the 2^p-th tick counted from entering low-power mode or from the previous timer launch, where p is configuration bits [2:0]. The tick counter is held at zero in modes 0 and 1.
- R6: A timer launch that falls while a conversion is still running is skipped, and the interval count restarts.
- R7: Address 2 reads code[10:3]. Address 3 reads code[2:0] in bits [7:5] and zeros in bits [4:0].
- R8: Both result bytes take the new code on the same edge, and they change on no other edge.
- R9: `done_irq` is high for exactly the one cycle after each edge that samples `sns_done` during a conversion. A `sns_done` that arrives with no conversion running is ignored.
- R10: In mode 1, `sns_pwr_sel` equals `bat_sel` (configuration bit 4). In the other modes, `sns_pwr_sel` follows control bit 0.
- R11: A change of power mode does not abort a running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_mode | input | 2 | Power mode: 0,1 active (1 battery-backed), 2,3 low power |
| tick | input | 1 | One-cycle slow timebase strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| sns_req | output | 1 | Conversion request to the sensor front end |
| sns_done | input | 1 | One-cycle conversion complete strobe |
| sns_code | input | 11 | Conversion result, two's complement |
| sns_pwr_sel | output | 1 | Sensor supply select |
| bat_sel | output | 1 | Battery measurement select |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions assume that the front end raises `sns_done` only as a single-cycle strobe and holds `sns_code` valid in that cycle. They also assume that `tick` is a one-cycle strobe, and that register writes and `pwr_mode` changes are synchronous to `clk`. The bench drives every input on the falling edge. It pulses `sns_done` and `tick` for exactly one cycle, and it drives a few stray `sns_done` strobes while idle on purpose to exercise R9.

// File: rtl/tsens_seq.sv
module tsens_seq #(
  parameter int CODE_W = 11,
  parameter int DW     = 8,
  parameter int PER_W  = 3,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pwr_mode,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              sns_req,
  input  logic              sns_done,
  input  logic [CODE_W-1:0] sns_code,
  output logic              sns_pwr_sel,
  output logic              bat_sel,
  output logic              done_irq
);

  localparam int LO_W  = CODE_W - DW;
  localparam int CNT_W = (1 << PER_W) - 1;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CFG  = AW'(1);
  localparam logic [AW-1:0] A_RHI  = AW'(2);
  localparam logic [AW-1:0] A_RLO  = AW'(3);
  localparam int START_BIT = 6;
  localparam int BUSY_BIT  = 5;
  localparam int BSEL_BIT  = 4;
  localparam int SUP_BIT   = 0;

  logic              busy_q, start_q, sup_q, bsel_q, irq_q;
  logic [PER_W-1:0]  per_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] res_q;
  logic [CNT_W:0]    span;

  wire lp_mode  = pwr_mode[1];
  wire ctrl_wr  = wr_en && (addr == A_CTRL);
  wire cfg_wr   = wr_en && (addr == A_CFG);
  wire cmd_go   = ctrl_wr && wdata[START_BIT] && !lp_mode && !busy_q;
  assign span   = (CNT_W+1)'(1) << per_q;
  wire cnt_last = ({1'b0, cnt_q} == (span - 1'b1));
  wire tmr_go   = lp_mode && tick && cnt_last && !busy_q;
  wire launch   = cmd_go || tmr_go;
  wire finish   = busy_q && sns_done;

  wire unused_wbits = &{1'b0, wdata[7], wdata[5], wdata[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      res_q   <= '0;
      cnt_q   <= '0;
    end else begin
      irq_q <= finish;
      if (launch)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      if (cmd_go)      start_q <= 1'b1;
      else if (finish) start_q <= 1'b0;
      if (finish)      res_q <= sns_code;
      if (!lp_mode)    cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q  <= 1'b0;
      bsel_q <= 1'b0;
      per_q  <= '0;
    end else begin
      if (ctrl_wr) sup_q <= wdata[SUP_BIT];
      if (cfg_wr) begin
        per_q  <= wdata[PER_W-1:0];
        bsel_q <= wdata[BSEL_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[START_BIT] = start_q;
        rdata[BUSY_BIT]  = busy_q;
        rdata[SUP_BIT]   = sup_q;
      end
      A_CFG: begin
        rdata[PER_W-1:0] = per_q;
        rdata[BSEL_BIT]  = bsel_q;
      end
      A_RHI: rdata = res_q[CODE_W-1:LO_W];
      A_RLO: rdata[DW-1:DW-LO_W] = res_q[LO_W-1:0];
      default: rdata = '0;
    endcase
  end

  assign sns_req     = busy_q;
  assign bat_sel     = bsel_q;
  assign sns_pwr_sel = (pwr_mode == 2'd1) ? bsel_q : sup_q;
  assign done_irq    = irq_q;

endmodule

// File: rtl/tsens_seq_chk.sv
module tsens_seq_chk #(
  parameter int CODE_W = 11,
  parameter int DW     = 8,
  parameter int AW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        pwr_mode,
  input logic              tick,
  input logic              wr_en,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic              sns_req,
  input logic              sns_done,
  input logic              done_irq,
  input logic [CODE_W-1:0] res_q
);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sns_req && !sns_done) |=> sns_req);

  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sns_req && sns_done) |=> !sns_req);

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(sns_req && sns_done));

  assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sns_req && sns_done) |=> $stable(res_q));

  assert_lp_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sns_req) && $past(pwr_mode[1])) |-> $past(tick));

  assert_act_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sns_req) && !$past(pwr_mode[1])) |->
      $past(wr_en && addr == '0 && wdata[6]));

endmodule

bind tsens_seq tsens_seq_chk #(.CODE_W(CODE_W), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .tick(tick),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .sns_req(sns_req),
  .sns_done(sns_done), .done_irq(done_irq), .res_q(res_q)
);

// File: tb/tsens_seq_tb_top.sv
`timescale 1ns/1ps
module tsens_seq_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, sns_done = 0;
  logic [1:0] pwr_mode = 0, addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [10:0] sns_code = 0;
  logic sns_req, sns_pwr_sel, bat_sel, done_irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tsens_seq dut_i (.clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .tick(tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .sns_req(sns_req),
    .sns_done(sns_done), .sns_code(sns_code), .sns_pwr_sel(sns_pwr_sel),
    .bat_sel(bat_sel), .done_irq(done_irq));

  // {code, high byte, low byte}
  localparam logic [26:0] VEC [7] = '{
    {11'h3FF, 8'h7F, 8'hE0}, {11'h400, 8'h80, 8'h00}, {11'h000, 8'h00, 8'h00},
    {11'h7FF, 8'hFF, 8'hE0}, {11'h155, 8'h2A, 8'hA0}, {11'h2AA, 8'h55, 8'h40},
    {11'h003, 8'h00, 8'h60}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic done_pulse(input logic [10:0] c);
    @(negedge clk); sns_done = 1; sns_code = c;
    @(negedge clk); sns_done = 0;
  endtask

  task automatic tick_pulse;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, hi, lo;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", sns_req, 0); chk("R1 irq", done_irq, 0);
    chk("R1 sel", {sns_pwr_sel, bat_sel}, 0);
    for (int a = 0; a < 4; a++) begin rd(a[1:0], d); chk("R1 reg", d, 0); end

    // Vector table: R2, R3, R7, R8, R9
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, 8'h40);
      chk("R2 req", sns_req, 1);
      rd(2'd0, d); chk("R2 ctrl", d, 8'h60);
      repeat (2) @(negedge clk);
      chk("R3 hold", sns_req, 1);
      done_pulse(VEC[i][26:16]);
      chk("R3 drop", sns_req, 0);
      chk("R9 irq", done_irq, 1);
      rd(2'd0, d); chk("R3 ctrl clear", d, 8'h00);
      rd(2'd2, hi); rd(2'd3, lo);
      chk("R7 hi", hi, VEC[i][15:8]); chk("R8 lo", lo, VEC[i][7:0]);
      @(negedge clk);
      chk("R9 single", done_irq, 0);
    end

    // R9 stray done while idle
    done_pulse(11'h123);
    chk("R9 stray irq", done_irq, 0);
    rd(2'd2, d); chk("R8 stray hi", d, 8'h00);
    rd(2'd3, d); chk("R8 stray lo", d, 8'h60);

    // R4 start while busy ignored
    wr(2'd0, 8'h40); wr(2'd0, 8'h40);
    done_pulse(11'h010);
    repeat (3) @(negedge clk);
    chk("R4 busy restart", sns_req, 0);

    // R4 start in low-power ignored
    wr(2'd1, 8'h07);
    pwr_mode = 2'd3;
    wr(2'd0, 8'h40);
    chk("R4 lp req", sns_req, 0);
    rd(2'd0, d); chk("R4 lp start", d, 8'h00);

    // R5 timer with p=2
    pwr_mode = 2'd0;
    wr(2'd1, 8'h02);
    pwr_mode = 2'd2;
    repeat (3) tick_pulse();
    chk("R5 early", sns_req, 0);
    tick_pulse();
    chk("R5 launch", sns_req, 1);
    rd(2'd0, d); chk("R5 start bit", d, 8'h20);
    done_pulse(11'h1F0);
    rd(2'd2, d); chk("R5 result", d, 8'h3E);
    repeat (3) tick_pulse();
    chk("R5 second early", sns_req, 0);
    tick_pulse();
    chk("R5 second launch", sns_req, 1);
    done_pulse(11'h000);

    // R6 skip while busy, p=0
    pwr_mode = 2'd0;
    wr(2'd1, 8'h00);
    pwr_mode = 2'd3;
    tick_pulse();
    chk("R6 launch", sns_req, 1);
    tick_pulse();
    done_pulse(11'h001);
    @(negedge clk);
    chk("R6 no queue", sns_req, 0);

    // R11 mode change keeps conversion
    pwr_mode = 2'd0;
    wr(2'd1, 8'h07);
    wr(2'd0, 8'h40);
    pwr_mode = 2'd2;
    repeat (2) @(negedge clk);
    chk("R11 running", sns_req, 1);
    done_pulse(11'h0F8);
    chk("R11 irq", done_irq, 1);
    rd(2'd2, d); chk("R11 result", d, 8'h1F);
    pwr_mode = 2'd0;

    // R10 select logic
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h00);
    pwr_mode = 2'd1; #1;
    chk("R10 batt mode", sns_pwr_sel, 1);
    chk("R10 bat_sel", bat_sel, 1);
    pwr_mode = 2'd0; #1;
    chk("R10 main mode", sns_pwr_sel, 0);
    wr(2'd0, 8'h01);
    chk("R10 supply bit", sns_pwr_sel, 1);
    wr(2'd1, 8'h00);
    pwr_mode = 2'd1; #1;
    chk("R10 batt forced", sns_pwr_sel, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule